// File: doc/BRIEF.md
# Windowed Bus Slave Address Decoder

This block decides, for one port of a dual-ported memory, whether a bus cycle falls inside the memory window assigned to that port. The window is a 128 MB partition chosen by the top five address bits. A start offset and an end offset, both in 512 KB steps, then narrow it from below and above. The configuration words come from straps that read inverted: a fitted strap is 0 and an open strap is 1.

Each cycle carries a 6-bit modifier code. The block accepts only the twelve memory codes. The 24-bit codes can be shut out with a mode strap. A 24-bit cycle decodes only address bits 23..0, so its upper byte counts as zero.

One instance serves each port, and each instance is configured on its own. The decode is taken once, on the rising edge of the address strobe. The select output and the long-word array index are then held until the strobe drops. The array index is built from the low address bits only, so two ports configured for different bus windows can reach the same cells.

Top module: `win_slave_decode`

## Requirements
- R1: In a 32-bit cycle, the select asserts only when address bits 31..27 equal the bitwise inverse of `cfg_part_n`.
- R2: Let s be the inverse of `cfg_start_n` and e the inverse of `cfg_end_n`. A cycle hits only when s <= addr[26:19] <= e, with both ends inclusive.
- R3: Every configuration input is active-low. An all-zero `cfg_part_n` selects partition 31. An all-ones `cfg_end_n` gives an end offset of 0.
- R4: When the decoded start offset is greater than the decoded end offset, the select never asserts, whatever the address or code.
- R5: Only the modifier codes 09, 0A, 0B, 0D, 0E and 0F (32-bit) and 39, 3A, 3B, 3D, 3E and 3F (24-bit), all in hex, can produce a select. The other 52 codes never do.
- R6: When `wide_only` is 1, the 24-bit codes (bits 5..4 = 11) are rejected.
- R7: In a 24-bit cycle, address bits 31..24 are treated as zero, both for the window compare and for the array index.
- R8: `arr_addr` equals bits MEM_LOG2-1..2 of the effective address (default MEM_LOG2 = 22, a 20-bit index). Addresses that differ only above bit MEM_LOG2-1 give the same index.
- R9: The decode is sampled at the first clock edge at which `strobe` is high, and `sel` and `arr_addr` show the result after that edge. Both hold unchanged while `strobe` stays high, even if the inputs change. `sel` clears after the first edge at which `strobe` is low.
- R10: Synchronous active-high reset clears `sel` and `arr_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Address strobe, active high |
| addr | input | 32 | Bus byte address |
| mod_code | input | 6 | Address modifier code |
| wide_only | input | 1 | 1 = accept 32-bit codes only |
| cfg_part_n | input | 5 | Partition select, active-low |
| cfg_start_n | input | 8 | Start offset in 512 KB steps, active-low |
| cfg_end_n | input | 8 | End offset in 512 KB steps, active-low |
| sel | output | 1 | Window hit, held for the strobe |
| arr_addr | output | MEM_LOG2-2 | Long-word array index |

## Verification
The code tests run all 64 modifier codes with both mode-strap settings, once with a clean low address and once with junk in the upper byte. This separates the accepted code set from the narrow-mode masking. Offset sweeps walk all 256 values of bits 26..19 against four windows: a wide range, a single step, a crossed pair and the full span. These catch off-by-one errors at each inclusive edge and the disable rule. A full 32-by-32 sweep of partition straps against address partitions exposes any bit mix-up in the inverted strap. A hold test changes the inputs during an active strobe to show that the sampled decode is held.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;

    localparam int ADDR_W   = 32;
    localparam int AM_W     = 6;
    localparam int PART_W   = 5;
    localparam int OFS_W    = 8;
    localparam int OFS_LSB  = 19;
    localparam int PART_LSB = OFS_LSB + OFS_W;   // 27
    localparam int NARROW_W = 24;
    localparam int HI_W     = ADDR_W - OFS_LSB;  // partition + offset bits

    typedef enum logic [1:0] {
        AM_REJECT = 2'd0,
        AM_EXT32  = 2'd1,
        AM_STD24  = 2'd2
    } am_kind_e;

    typedef struct packed {
        logic [PART_W-1:0] part;
        logic [OFS_W-1:0]  lo;
        logic [OFS_W-1:0]  hi;
    } win_cfg_t;

    typedef struct packed {
        logic accept;
        logic narrow;
    } am_verdict_t;

    // Memory codes: the low nibble must be a data/program space code, the
    // upper pair selects 32-bit (00) or 24-bit (11) addressing.
    function automatic am_kind_e classify_am(input logic [AM_W-1:0] code);
        logic nib_ok;
        nib_ok = code[3] && (code[1:0] != 2'b00);
        unique case (code[5:4])
            2'b00:   classify_am = nib_ok ? AM_EXT32 : AM_REJECT;
            2'b11:   classify_am = nib_ok ? AM_STD24 : AM_REJECT;
            default: classify_am = AM_REJECT;
        endcase
    endfunction

    function automatic win_cfg_t decode_straps(input logic [PART_W-1:0] part_n,
                                               input logic [OFS_W-1:0]  lo_n,
                                               input logic [OFS_W-1:0]  hi_n);
        win_cfg_t c;
        c.part = ~part_n;
        c.lo   = ~lo_n;
        c.hi   = ~hi_n;
        return c;
    endfunction

endpackage

// File: rtl/win_am_filter.sv
module win_am_filter
    import win_dec_pkg::*;
(
    input  logic [AM_W-1:0] code,
    input  logic            wide_only,
    output am_verdict_t     verdict
);
    am_kind_e kind;

    always_comb begin
        kind = classify_am(code);
        verdict.narrow = (kind == AM_STD24);
        unique case (kind)
            AM_EXT32: verdict.accept = 1'b1;
            AM_STD24: verdict.accept = ~wide_only;
            default:  verdict.accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/win_addr_map.sv
module win_addr_map
    import win_dec_pkg::*;
#(
    parameter int MEM_LOG2 = 22,
    localparam int ARR_W   = MEM_LOG2 - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              narrow,
    output logic [HI_W-1:0]   eff_hi,
    output logic [ARR_W-1:0]  arr_idx
);
    localparam int ZERO_W = ADDR_W - NARROW_W;

    // Upper part used by the window compare.
    always_comb begin
        if (narrow)
            eff_hi = {{ZERO_W{1'b0}}, addr[NARROW_W-1:OFS_LSB]};
        else
            eff_hi = addr[ADDR_W-1:OFS_LSB];
    end

    // Long-word index; only sizes above the 24-bit span need masking.
    generate
        if (MEM_LOG2 > NARROW_W) begin : g_big
            localparam int TOP_W = MEM_LOG2 - NARROW_W;
            assign arr_idx = {addr[MEM_LOG2-1:NARROW_W] & {TOP_W{~narrow}},
                              addr[NARROW_W-1:2]};
        end else begin : g_small
            assign arr_idx = addr[MEM_LOG2-1:2];
        end
    endgenerate
endmodule

// File: rtl/win_range_cmp.sv
module win_range_cmp
    import win_dec_pkg::*;
(
    input  logic [HI_W-1:0] eff_hi,
    input  win_cfg_t        cfg,
    output logic            in_window
);
    logic [PART_W-1:0] a_part;
    logic [OFS_W-1:0]  a_ofs;
    logic              part_eq;
    logic              above_lo;
    logic              below_hi;

    always_comb begin
        a_part    = eff_hi[HI_W-1:OFS_W];
        a_ofs     = eff_hi[OFS_W-1:0];
        part_eq   = (a_part == cfg.part);
        above_lo  = (a_ofs >= cfg.lo);
        below_hi  = (a_ofs <= cfg.hi);
        // A crossed pair (lo > hi) leaves no offset satisfying both bounds.
        in_window = part_eq && above_lo && below_hi;
    end
endmodule

// File: rtl/win_slave_decode.sv
module win_slave_decode
    import win_dec_pkg::*;
#(
    parameter int MEM_LOG2 = 22,
    localparam int ARR_W   = MEM_LOG2 - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [31:0]       addr,
    input  logic [5:0]        mod_code,
    input  logic              wide_only,
    input  logic [4:0]        cfg_part_n,
    input  logic [7:0]        cfg_start_n,
    input  logic [7:0]        cfg_end_n,
    output logic              sel,
    output logic [ARR_W-1:0]  arr_addr
);
    am_verdict_t       verdict;
    win_cfg_t          cfg;
    logic [HI_W-1:0]   eff_hi;
    logic [ARR_W-1:0]  idx_next;
    logic              in_window;
    logic              hit_next;
    logic              strobe_q;
    logic              take;
    logic              unused_byte_lane;

    assign unused_byte_lane = ^addr[1:0];
    assign cfg = decode_straps(cfg_part_n, cfg_start_n, cfg_end_n);

    win_am_filter u_am (
        .code      (mod_code),
        .wide_only (wide_only),
        .verdict   (verdict)
    );

    win_addr_map #(.MEM_LOG2(MEM_LOG2)) u_map (
        .addr    (addr),
        .narrow  (verdict.narrow),
        .eff_hi  (eff_hi),
        .arr_idx (idx_next)
    );

    win_range_cmp u_cmp (
        .eff_hi    (eff_hi),
        .cfg       (cfg),
        .in_window (in_window)
    );

    assign hit_next = verdict.accept && in_window;
    assign take     = strobe && !strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            sel      <= 1'b0;
            arr_addr <= '0;
        end else begin
            strobe_q <= strobe;
            if (!strobe) begin
                sel <= 1'b0;
            end else if (take) begin
                sel      <= hit_next;
                arr_addr <= idx_next;
            end
        end
    end
endmodule

// File: rtl/win_slave_decode_chk.sv
module win_slave_decode_chk #(
    parameter int MEM_LOG2 = 22,
    localparam int ARR_W   = MEM_LOG2 - 2
) (
    input logic             clk,
    input logic             rst,
    input logic             strobe,
    input logic [31:0]      addr,
    input logic [5:0]       mod_code,
    input logic             wide_only,
    input logic [4:0]       cfg_part_n,
    input logic [7:0]       cfg_start_n,
    input logic [7:0]       cfg_end_n,
    input logic             sel,
    input logic [ARR_W-1:0] arr_addr
);
    logic seen;
    logic first;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= strobe;
    end
    assign first = strobe && !seen;

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!sel && arr_addr == '0));

    p_drop_with_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> !sel);

    p_hold_index_r9: assert property (@(posedge clk) disable iff (rst)
        (strobe && seen) |=> $stable(arr_addr));

    p_hold_sel_r9: assert property (@(posedge clk) disable iff (rst)
        (strobe && seen && strobe != 1'b0) |=> (strobe ? $stable(sel) : 1'b1));

    p_crossed_off_r4: assert property (@(posedge clk) disable iff (rst)
        (first && (~cfg_start_n > ~cfg_end_n)) |=> !sel);

    p_odd_code_r5: assert property (@(posedge clk) disable iff (rst)
        (first && (mod_code[5] != mod_code[4])) |=> !sel);

    p_wide_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (first && wide_only && mod_code[5:4] == 2'b11) |=> !sel);

    p_partition_r1: assert property (@(posedge clk) disable iff (rst)
        (first && mod_code[5:4] == 2'b00 && addr[31:27] != ~cfg_part_n) |=> !sel);
endmodule

bind win_slave_decode win_slave_decode_chk #(.MEM_LOG2(MEM_LOG2)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .addr        (addr),
    .mod_code    (mod_code),
    .wide_only   (wide_only),
    .cfg_part_n  (cfg_part_n),
    .cfg_start_n (cfg_start_n),
    .cfg_end_n   (cfg_end_n),
    .sel         (sel),
    .arr_addr    (arr_addr)
);

// File: tb/win_slave_decode_test.sv
`timescale 1ns/1ps
module win_slave_decode_test;
    localparam int MEM_LOG2 = 22;
    localparam int ARR_W    = MEM_LOG2 - 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             strobe = 1'b0;
    logic [31:0]      addr = '0;
    logic [5:0]       mod_code = '0;
    logic             wide_only = 1'b0;
    logic [4:0]       cfg_part_n = '1;
    logic [7:0]       cfg_start_n = '1;
    logic [7:0]       cfg_end_n = '0;
    logic             sel;
    logic [ARR_W-1:0] arr_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    win_slave_decode #(.MEM_LOG2(MEM_LOG2)) uut (
        .clk(clk), .rst(rst), .strobe(strobe), .addr(addr),
        .mod_code(mod_code), .wide_only(wide_only), .cfg_part_n(cfg_part_n),
        .cfg_start_n(cfg_start_n), .cfg_end_n(cfg_end_n),
        .sel(sel), .arr_addr(arr_addr)
    );

    function automatic bit code_ok(input logic [5:0] c, input bit wide);
        bit is32, is24;
        is32 = c inside {6'h09, 6'h0A, 6'h0B, 6'h0D, 6'h0E, 6'h0F};
        is24 = c inside {6'h39, 6'h3A, 6'h3B, 6'h3D, 6'h3E, 6'h3F};
        return is32 || (is24 && !wide);
    endfunction

    function automatic longint eff_of(input logic [31:0] a, input logic [5:0] c);
        if (c[5:4] == 2'b11) return longint'(a) % (64'd1 << 24);
        return longint'(a);
    endfunction

    function automatic bit exp_hit(input logic [31:0] a, input logic [5:0] c, input bit wide);
        longint e;
        int part, ofs, lo, hi;
        e    = eff_of(a, c);
        part = int'(e / (64'd1 << 27));
        ofs  = int'((e / (64'd1 << 19)) % 256);
        lo   = 255 - int'(cfg_start_n);
        hi   = 255 - int'(cfg_end_n);
        return code_ok(c, wide) && (part == 31 - int'(cfg_part_n)) && ofs >= lo && ofs <= hi;
    endfunction

    function automatic longint exp_idx(input logic [31:0] a, input logic [5:0] c);
        return (eff_of(a, c) % (64'd1 << MEM_LOG2)) / 4;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int part, input int lo, input int hi);
        cfg_part_n  = 5'(31 - part);
        cfg_start_n = 8'(255 - lo);
        cfg_end_n   = 8'(255 - hi);
    endtask

    // One strobe: starts and ends at a falling edge.
    task automatic cycle(input logic [31:0] a, input logic [5:0] c, input bit wide, input string req);
        bit eh;
        longint ei;
        eh = exp_hit(a, c, wide);
        ei = exp_idx(a, c);
        addr = a; mod_code = c; wide_only = wide; strobe = 1'b1;
        @(posedge clk); @(negedge clk);
        check(sel == eh, req, longint'(sel), longint'(eh));
        if (eh) check(longint'(arr_addr) == ei, "R8 index", longint'(arr_addr), ei);
        strobe = 1'b0;
        @(posedge clk); @(negedge clk);
        check(sel == 1'b0, "R9 release", longint'(sel), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(sel == 1'b0, "R10 sel", longint'(sel), 0);
        check(arr_addr == '0, "R10 arr", longint'(arr_addr), 0);
        rst = 1'b0;
        @(negedge clk);

        // R5 R6 R7: every code, both strap settings, clean and junk upper byte
        set_cfg(0, 2, 30);
        for (int w = 0; w < 2; w++)
            for (int c = 0; c < 64; c++) begin
                cycle(32'h00A0_1238, 6'(c), bit'(w), "R5 R6 code");
                cycle(32'hC0A0_1238, 6'(c), bit'(w), "R7 narrow mask");
            end

        // R2 inclusive bounds
        set_cfg(3, 10, 200);
        for (int o = 0; o < 256; o++)
            cycle((32'd3 << 27) | (32'(o) << 19) | 32'(o * 52), 6'h09, 1'b0, "R2 range");
        set_cfg(3, 77, 77);
        for (int o = 0; o < 256; o++)
            cycle((32'd3 << 27) | (32'(o) << 19), 6'h0D, 1'b1, "R2 single step");
        // R4 crossed offsets disable the port
        set_cfg(3, 78, 77);
        for (int o = 0; o < 256; o++) begin
            cycle((32'd3 << 27) | (32'(o) << 19), 6'h0F, 1'b0, "R4 disabled");
            check(sel == 1'b0, "R4 idle", longint'(sel), 0);
        end
        set_cfg(3, 0, 255);
        for (int o = 0; o < 256; o++)
            cycle((32'd3 << 27) | (32'(o) << 19) | 32'h44, 6'h0A, 1'b0, "R2 full span");

        // R1 R3 partitions: every strap value against every address partition
        for (int p = 0; p < 32; p++) begin
            set_cfg(p, 0, 255);
            for (int q = 0; q < 32; q++)
                cycle((32'(q) << 27) | 32'h0123_4560, 6'h0B, 1'b0, "R1 R3 partition");
        end
        // R3 raw strap encodings
        cfg_part_n = 5'h00; cfg_start_n = 8'hFF; cfg_end_n = 8'h00;
        cycle(32'hF800_0000, 6'h09, 1'b0, "R3 all fitted part");
        cfg_end_n = 8'hFF;
        cycle(32'hF800_0000, 6'h09, 1'b0, "R3 end zero low");
        cycle(32'hF808_0000, 6'h09, 1'b0, "R3 end zero high");

        // R8 aliasing: two windows, same low bits, same index
        begin
            logic [ARR_W-1:0] first_idx;
            set_cfg(1, 0, 255);
            cycle(32'h0812_3454, 6'h09, 1'b0, "R8 alias a");
            first_idx = arr_addr;
            set_cfg(6, 0, 255);
            cycle(32'h3012_3454, 6'h09, 1'b0, "R8 alias b");
            check(arr_addr == first_idx, "R8 alias", longint'(arr_addr), longint'(first_idx));
        end

        // R9 hold: inputs change while strobe stays high
        set_cfg(2, 0, 255);
        addr = 32'h1034_5678; mod_code = 6'h0E; wide_only = 1'b0; strobe = 1'b1;
        @(posedge clk); @(negedge clk);
        check(sel == 1'b1, "R9 take", longint'(sel), 1);
        check(longint'(arr_addr) == ((64'h1034_5678 % (64'd1 << 22)) / 4),
              "R9 take idx", longint'(arr_addr), (64'h1034_5678 % (64'd1 << 22)) / 4);
        for (int k = 0; k < 3; k++) begin
            addr = 32'h7000_0000 + 32'(k * 4); mod_code = 6'h2C;
            @(posedge clk); @(negedge clk);
            check(sel == 1'b1, "R9 hold sel", longint'(sel), 1);
            check(longint'(arr_addr) == ((64'h1034_5678 % (64'd1 << 22)) / 4),
                  "R9 hold idx", longint'(arr_addr), (64'h1034_5678 % (64'd1 << 22)) / 4);
        end
        strobe = 1'b0;
        @(posedge clk); @(negedge clk);
        check(sel == 1'b0, "R9 drop", longint'(sel), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule